// File: doc/BRIEF.md
# Instruction Fetch Patch Redirector

This block lets firmware replace faulty instructions that are fixed in mask ROM. It holds two correction channels. Each channel has an 18-bit fetch address to watch, a 16-bit vector that points at replacement code, and an enable flag. Firmware programs all of them one byte at a time over a simple register bus with separate write and read strobes.

The block compares every valid instruction fetch address against the enabled channels in the same cycle. On a hit it raises a single-cycle redirect and presents the channel's vector, widened with zeros to 18 bits, as the new program counter. The fetch unit then branches there instead of using the ROM word. If both channels hit at once, channel 0 wins. The enable flags clear on reset, so the match addresses do not need a reset value.

Top module: `rom_patch_redirect`

## Requirements
- R1: After reset both enable flags are 0, the control byte and all four vector bytes read 0x00, and no fetch address produces a redirect.
- R2: Channel 0 match address bytes sit at 0x03FC7 (bits 7:0), 0x03FC8 (bits 15:8) and 0x03FC9 (bits 17:16 taken from write data bits 1:0). Channel 1 uses 0x03FCA, 0x03FCB and 0x03FCC in the same way. Each byte reads back what was last written, and one bus access writes at most one register.
- R3: Bits 7:2 of a high address byte read 0. A read of an unmapped address, or any cycle with the read strobe low, returns 0x00.
- R4: The control byte at 0x03FC6 holds the channel 0 enable in bit 0 and the channel 1 enable in bit 1. It takes effect on the clock edge of the write, and bits 7:2 read 0.
- R5: Vector bytes sit at 0x03FCD (channel 0, bits 7:0), 0x03FCE (channel 0, bits 15:8), 0x03FCF (channel 1, bits 7:0) and 0x03FD0 (channel 1, bits 15:8). Each reads back what was last written.
- R6: In a cycle where fetchValid is 1 and fetchAddr equals an enabled channel's match address, redirect is 1 in that same cycle and redirectPc is {2'b00, vector}. Otherwise redirect is 0 and redirectPc is 0.
- R7: A channel whose enable is 0 never redirects, even when its match address equals fetchAddr.
- R8: When both channels hit in the same cycle, redirectPc carries channel 0's vector.
- R9: A register write takes effect on the clock edge that ends the write cycle. A fetch in that same cycle is compared against the old contents, and a fetch in the next cycle uses the new contents.
- R10: A fetch address that differs from the match address in any single bit, including bit 17, does not redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 18 | Register bus address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, valid in the cycle of regRdEn |
| fetchAddr | input | 18 | Instruction fetch address |
| fetchValid | input | 1 | Fetch address valid strobe |
| redirect | output | 1 | Redirect pulse, one per matching valid fetch |
| redirectPc | output | 18 | Replacement program counter, zero when no redirect |

## Verification
Two things can happen in the same cycle: a register write, such as a match byte, a vector byte or the control byte, and a fetch comparison that depends on it. The bench sets this up directly. It rewrites the low byte of a live channel while presenting that channel's matching fetch address. It expects the redirect in that cycle, because the comparison still uses the old byte, and expects no redirect when the same address is fetched one cycle later. A behavioural model updates its state only after the clock edge and is compared every cycle, which also covers random mixes of writes, reads and fetches.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int NUM_CH   = 2;
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BYTE_W   = 8;
  localparam int MATCH_W  = 18;
  localparam int VEC_W    = 16;
  localparam int HI_W     = MATCH_W - 2 * BYTE_W;
  localparam int REG_AW   = 18;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_LO, RD_MID, RD_HI, RD_VLO, RD_VHI
  } rdField_e;

  typedef struct packed {
    logic                wrCtrl;
    logic [NUM_CH-1:0]   wrLo;
    logic [NUM_CH-1:0]   wrMid;
    logic [NUM_CH-1:0]   wrHi;
    logic [NUM_CH-1:0]   wrVecLo;
    logic [NUM_CH-1:0]   wrVecHi;
    rdField_e            rdField;
    logic [CH_IDX_W-1:0] rdChan;
    logic [BYTE_W-1:0]   data;
  } regStrobe_t;
endpackage

// File: rtl/rpr_decode.sv
module rpr_decode
  import rpr_pkg::*;
#(
  parameter logic [REG_AW-1:0] CTRL_ADDR  = 18'h03FC6,
  parameter logic [REG_AW-1:0] MATCH_BASE = 18'h03FC7,
  parameter logic [REG_AW-1:0] VEC_BASE   = 18'h03FCD
) (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [BYTE_W-1:0] regWrData,
  output regStrobe_t        strb
);
  localparam int MATCH_STRIDE = 3;
  localparam int VEC_STRIDE   = 2;

  always_comb begin
    strb         = '0;
    strb.rdField = RD_NONE;
    strb.data    = regWrData;
    if (regAddr == CTRL_ADDR) begin
      strb.wrCtrl = regWrEn;
      if (regRdEn) strb.rdField = RD_CTRL;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == MATCH_BASE + REG_AW'(MATCH_STRIDE * c)) begin
        strb.wrLo[c] = regWrEn;
        if (regRdEn) begin strb.rdField = RD_LO; strb.rdChan = CH_IDX_W'(c); end
      end
      if (regAddr == MATCH_BASE + REG_AW'(MATCH_STRIDE * c + 1)) begin
        strb.wrMid[c] = regWrEn;
        if (regRdEn) begin strb.rdField = RD_MID; strb.rdChan = CH_IDX_W'(c); end
      end
      if (regAddr == MATCH_BASE + REG_AW'(MATCH_STRIDE * c + 2)) begin
        strb.wrHi[c] = regWrEn;
        if (regRdEn) begin strb.rdField = RD_HI; strb.rdChan = CH_IDX_W'(c); end
      end
      if (regAddr == VEC_BASE + REG_AW'(VEC_STRIDE * c)) begin
        strb.wrVecLo[c] = regWrEn;
        if (regRdEn) begin strb.rdField = RD_VLO; strb.rdChan = CH_IDX_W'(c); end
      end
      if (regAddr == VEC_BASE + REG_AW'(VEC_STRIDE * c + 1)) begin
        strb.wrVecHi[c] = regWrEn;
        if (regRdEn) begin strb.rdField = RD_VHI; strb.rdChan = CH_IDX_W'(c); end
      end
    end
  end
endmodule

// File: rtl/rpr_datapath.sv
module rpr_datapath
  import rpr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  regStrobe_t                    strb,
  input  logic [MATCH_W-1:0]            fetchAddr,
  input  logic                          fetchValid,
  output logic [NUM_CH-1:0]             chHit,
  output logic [NUM_CH-1:0][VEC_W-1:0]  chVec,
  output logic [BYTE_W-1:0]             rdData
);
  logic [NUM_CH-1:0]                chEn;
  logic [NUM_CH-1:0][MATCH_W-1:0]   matchAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chEn <= '0;
    else if (strb.wrCtrl) chEn <= strb.data[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MATCH_W-1:0] addrQ;
    logic [VEC_W-1:0]   vecQ;

    // Match address has no reset: enable clears on reset instead.
    always_ff @(posedge clk) begin
      if (strb.wrLo[c])  addrQ[BYTE_W-1:0]          <= strb.data;
      if (strb.wrMid[c]) addrQ[2*BYTE_W-1:BYTE_W]   <= strb.data;
      if (strb.wrHi[c])  addrQ[MATCH_W-1:2*BYTE_W]  <= strb.data[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vecQ <= '0;
      else begin
        if (strb.wrVecLo[c]) vecQ[BYTE_W-1:0]      <= strb.data;
        if (strb.wrVecHi[c]) vecQ[VEC_W-1:BYTE_W]  <= strb.data;
      end
    end

    assign matchAddr[c] = addrQ;
    assign chVec[c]     = vecQ;
    assign chHit[c]     = fetchValid && chEn[c] && (fetchAddr == addrQ);
  end

  always_comb begin
    case (strb.rdField)
      RD_CTRL: rdData = BYTE_W'(chEn);
      RD_LO:   rdData = matchAddr[strb.rdChan][BYTE_W-1:0];
      RD_MID:  rdData = matchAddr[strb.rdChan][2*BYTE_W-1:BYTE_W];
      RD_HI:   rdData = BYTE_W'(matchAddr[strb.rdChan][MATCH_W-1:2*BYTE_W]);
      RD_VLO:  rdData = chVec[strb.rdChan][BYTE_W-1:0];
      RD_VHI:  rdData = chVec[strb.rdChan][VEC_W-1:BYTE_W];
      default: rdData = '0;
    endcase
  end

  // R2: the decoder never raises two write strobes for one access
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strb.wrCtrl, strb.wrLo, strb.wrMid, strb.wrHi,
                strb.wrVecLo, strb.wrVecHi}) <= 1);

  // R3: unimplemented high-byte bits read back as zero
  p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdField == RD_HI) |-> (rdData[BYTE_W-1:HI_W] == '0));

  // R4: a control write lands on the next edge
  p_ctrl_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrCtrl |=> (chEn == $past(strb.data[NUM_CH-1:0])));

  // R7: a disabled channel never reports a hit
  p_no_hit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chEn == '0) |-> (chHit == '0));
endmodule

// File: rtl/rpr_redirect.sv
module rpr_redirect
  import rpr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fetchValid,
  input  logic [NUM_CH-1:0]             chHit,
  input  logic [NUM_CH-1:0][VEC_W-1:0]  chVec,
  output logic                          redirect,
  output logic [MATCH_W-1:0]            redirectPc
);
  logic [NUM_CH-1:0] grant;

  always_comb begin
    grant = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (chHit[c]) grant = NUM_CH'(1) << c;
    end
  end

  always_comb begin
    redirectPc = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grant[c]) redirectPc = redirectPc | MATCH_W'(chVec[c]);
    end
  end

  assign redirect = |grant;

  // R8: at most one channel is granted
  p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8: channel 0 wins whenever it hits
  p_prio_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chHit[0] |-> (redirectPc == MATCH_W'(chVec[0])));

  // R6: redirect only with a valid fetch
  p_fetch_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetchValid);

  // R6: no redirect leaves the pc output at zero
  p_idle_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> (redirectPc == '0));
endmodule

// File: rtl/rom_patch_redirect.sv
module rom_patch_redirect
  import rpr_pkg::*;
#(
  parameter logic [REG_AW-1:0] CTRL_ADDR  = 18'h03FC6,
  parameter logic [REG_AW-1:0] MATCH_BASE = 18'h03FC7,
  parameter logic [REG_AW-1:0] VEC_BASE   = 18'h03FCD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [BYTE_W-1:0]  regWrData,
  output logic [BYTE_W-1:0]  regRdData,
  input  logic [MATCH_W-1:0] fetchAddr,
  input  logic               fetchValid,
  output logic               redirect,
  output logic [MATCH_W-1:0] redirectPc
);
  regStrobe_t                   strb;
  logic [NUM_CH-1:0]            chHit;
  logic [NUM_CH-1:0][VEC_W-1:0] chVec;

  rpr_decode #(
    .CTRL_ADDR (CTRL_ADDR),
    .MATCH_BASE(MATCH_BASE),
    .VEC_BASE  (VEC_BASE)
  ) decode_i (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regWrData(regWrData),
    .strb     (strb)
  );

  rpr_datapath datapath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .fetchAddr (fetchAddr),
    .fetchValid(fetchValid),
    .chHit     (chHit),
    .chVec     (chVec),
    .rdData    (regRdData)
  );

  rpr_redirect redirect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetchValid(fetchValid),
    .chHit     (chHit),
    .chVec     (chVec),
    .redirect  (redirect),
    .redirectPc(redirectPc)
  );
endmodule

// File: tb/rom_patch_redirect_tb_top.sv
`timescale 1ns/1ps
module rom_patch_redirect_tb_top;
  localparam time CYC = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [17:0] fetchAddr = '0;
  logic        fetchValid = 1'b0;
  logic        redirect;
  logic [17:0] redirectPc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [17:0] mAddr [2];
  logic [15:0] mVec  [2];
  logic [1:0]  mEn;

  always #(CYC/2) clk = ~clk;

  rom_patch_redirect dut_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .fetchAddr(fetchAddr), .fetchValid(fetchValid),
    .redirect(redirect), .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic re, input logic [17:0] a);
    if (!re) return 8'h00;
    case (a)
      18'h03FC6: return {6'b0, mEn};
      18'h03FC7: return mAddr[0][7:0];
      18'h03FC8: return mAddr[0][15:8];
      18'h03FC9: return {6'b0, mAddr[0][17:16]};
      18'h03FCA: return mAddr[1][7:0];
      18'h03FCB: return mAddr[1][15:8];
      18'h03FCC: return {6'b0, mAddr[1][17:16]};
      18'h03FCD: return mVec[0][7:0];
      18'h03FCE: return mVec[0][15:8];
      18'h03FCF: return mVec[1][7:0];
      18'h03FD0: return mVec[1][15:8];
      default:   return 8'h00;
    endcase
  endfunction

  task automatic modelWrite(input logic [17:0] a, input logic [7:0] d);
    case (a)
      18'h03FC6: mEn = d[1:0];
      18'h03FC7: mAddr[0][7:0] = d;
      18'h03FC8: mAddr[0][15:8] = d;
      18'h03FC9: mAddr[0][17:16] = d[1:0];
      18'h03FCA: mAddr[1][7:0] = d;
      18'h03FCB: mAddr[1][15:8] = d;
      18'h03FCC: mAddr[1][17:16] = d[1:0];
      18'h03FCD: mVec[0][7:0] = d;
      18'h03FCE: mVec[0][15:8] = d;
      18'h03FCF: mVec[1][7:0] = d;
      18'h03FD0: mVec[1][15:8] = d;
      default: ;
    endcase
  endtask

  // One bus/fetch cycle: drive at negedge, judge before posedge, update model after it.
  task automatic step(input logic we, input logic re, input logic [17:0] a,
                      input logic [7:0] d, input logic fv, input logic [17:0] fa,
                      input string req);
    logic hit0, hit1, expRedir;
    logic [17:0] expPc;
    @(negedge clk);
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = d;
    fetchValid = fv; fetchAddr = fa;
    #(CYC/4);
    hit0 = fv && mEn[0] && (fa == mAddr[0]);
    hit1 = fv && mEn[1] && (fa == mAddr[1]);
    expRedir = hit0 || hit1;
    expPc = hit0 ? {2'b00, mVec[0]} : (hit1 ? {2'b00, mVec[1]} : 18'h0);
    chk(req, "redirect", 32'(redirect), 32'(expRedir));
    chk(req, "redirectPc", 32'(redirectPc), 32'(expPc));
    chk(req, "regRdData", 32'(regRdData), 32'(expRead(re, a)));
    @(posedge clk);
    #1;
    if (we) modelWrite(a, d);
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d, input string req);
    step(1'b1, 1'b0, a, d, 1'b0, 18'h0, req);
  endtask
  task automatic rd(input logic [17:0] a, input string req);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, 18'h0, req);
  endtask
  task automatic fetch(input logic [17:0] fa, input logic fv, input string req);
    step(1'b0, 1'b0, 18'h0, 8'h00, fv, fa, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mEn = 2'b00; mVec[0] = '0; mVec[1] = '0; mAddr[0] = '0; mAddr[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state of enables and vectors; no redirect while disabled
    rd(18'h03FC6, "R1");
    rd(18'h03FCD, "R1"); rd(18'h03FCE, "R1");
    rd(18'h03FCF, "R1"); rd(18'h03FD0, "R1");
    fetch(18'h00000, 1'b1, "R1");
    fetch(18'h3FFFF, 1'b1, "R1");

    // R2/R3: channel 0 address bytes; high byte keeps only two bits
    wr(18'h03FC7, 8'hC3, "R2"); wr(18'h03FC8, 8'hA5, "R2");
    wr(18'h03FC9, 8'hFE, "R3");
    rd(18'h03FC7, "R2"); rd(18'h03FC8, "R2"); rd(18'h03FC9, "R3");
    // R5: vectors
    wr(18'h03FCD, 8'h34, "R5"); wr(18'h03FCE, 8'h12, "R5");
    wr(18'h03FCF, 8'hEF, "R5"); wr(18'h03FD0, 8'hBE, "R5");
    rd(18'h03FCD, "R5"); rd(18'h03FCE, "R5");
    rd(18'h03FCF, "R5"); rd(18'h03FD0, "R5");

    // R7: matching address but channel disabled
    fetch(18'h2A5C3, 1'b1, "R7");

    // R4: control byte, unused bits read 0
    wr(18'h03FC6, 8'hFF, "R4"); rd(18'h03FC6, "R4");
    wr(18'h03FC6, 8'h01, "R4"); rd(18'h03FC6, "R4");

    // R6: hit with valid, none without valid
    fetch(18'h2A5C3, 1'b1, "R6");
    fetch(18'h2A5C3, 1'b0, "R6");
    // R10: single-bit differences
    fetch(18'h0A5C3, 1'b1, "R10");
    fetch(18'h2A5C2, 1'b1, "R10");
    fetch(18'h2A4C3, 1'b1, "R10");

    // R8: both channels on the same address
    wr(18'h03FCA, 8'hC3, "R2"); wr(18'h03FCB, 8'hA5, "R2");
    wr(18'h03FCC, 8'h02, "R2");
    rd(18'h03FCA, "R2"); rd(18'h03FCC, "R2");
    wr(18'h03FC6, 8'h03, "R8");
    fetch(18'h2A5C3, 1'b1, "R8");
    wr(18'h03FC6, 8'h02, "R6");
    fetch(18'h2A5C3, 1'b1, "R6");

    // R9: write to live channel in the same cycle as a matching fetch
    step(1'b1, 1'b0, 18'h03FCA, 8'h00, 1'b1, 18'h2A5C3, "R9");
    fetch(18'h2A5C3, 1'b1, "R9");
    fetch(18'h2A500, 1'b1, "R9");
    // R9: enable written in the fetch cycle acts only from next cycle
    step(1'b1, 1'b0, 18'h03FC6, 8'h01, 1'b1, 18'h2A5C3, "R9");
    fetch(18'h2A5C3, 1'b1, "R9");

    // R3: unmapped reads and read strobe low
    rd(18'h03FD1, "R3"); rd(18'h03FC5, "R3");
    step(1'b0, 1'b0, 18'h03FC7, 8'h00, 1'b0, 18'h0, "R3");

    // R6: random mix checked against the model every cycle
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a, fa;
      logic we, re, fv;
      a  = 18'h03FC6 + 18'($urandom_range(0, 11));
      we = ($urandom_range(0, 2) == 0);
      re = $urandom_range(0, 1) == 1;
      fv = $urandom_range(0, 3) != 0;
      case ($urandom_range(0, 2))
        0: fa = mAddr[0];
        1: fa = mAddr[1];
        default: fa = 18'($urandom_range(0, 262143));
      endcase
      step(we, re, a, 8'($urandom_range(0, 255)), fv, fa, "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule